// File: doc/BRIEF.md
# Multi-pipe FIFO port controller

This block is the processor-side access window onto a set of endpoint pipe buffers. Software picks one buffer through a select register, then moves data through a single data register. It reads a ready flag and a length count for the chosen buffer from a status register. Each buffer is a small FIFO that keeps a 10-bit count of the words it holds. The serial bus engine is modelled by plain inputs: it writes received words, marks a packet complete, and reports per-pipe NAK and busy state.

When the selected pipe or the transfer direction changes, the status fields pass through a defined window. They first hold their old values, then read as zero with an invalid flag, and then show the new buffer's values. Two recovery commands work on the engine side of a buffer. A toggle hands the buffer to the processor so it can be read before the engine has finished with it. A clear discards data waiting to be sent. Both are taken only when the pipe answers NAK and the engine is idle for it. Both are refused on pipe 0, the default control pipe. An accepted command raises interrupt pulses. A refused command on another pipe sets a sticky error bit.

Register map (16-bit data bus): address 0 SELECT, address 1 CONTROL, address 2 STATUS, address 3 DATA. SELECT holds the pipe number in its low bits, the direction in bit 8 (1 = processor writes) and read-count mode in bit 9. A write to CONTROL with bit 0 set is a toggle and with bit 1 set is a clear. Reading CONTROL returns the error bit in bit 0. STATUS gives ready in bit 15, invalid in bit 14 and the length in bits 9:0. Reads return data combinationally from the register address; only a read strobe causes side effects.

Top module: `fifo_port_ctrl`

## Requirements
- R1: After reset, SELECT reads 0 (pipe 0, read direction, read-count off), STATUS reads ready 0, invalid 0, length 0, the error bit reads 0 and both interrupts are low.
- R2: In read direction, words written by the engine to a pipe, followed by a packet-done pulse, make that pipe ready (STATUS bit 15 = 1). DATA reads then return the words in arrival order.
- R3: A SELECT write that changes the pipe starts a window. STATUS keeps its previous value for HOLD_CYC cycles, then reads ready 0, length 0, invalid 1 (bit 14) until VALID_CYC cycles after the write. From then on it shows the new pipe. Ready is low no later than LOW_CYC cycles after the write.
- R4: A SELECT write that changes only the direction bit starts the same window. A SELECT write that changes neither pipe nor direction starts no window.
- R5: A toggle (CONTROL bit 0) on a pipe other than 0, while its NAK input is 1 and its busy input is 0, makes the pipe ready in read direction so its data can be read. irq_buf pulses high for the one cycle after the write.
- R6: A clear (CONTROL bit 1) under the same conditions empties the pipe to length 0 and discards its data. irq_buf and irq_empty pulse together for the one cycle after the write. In write direction the pipe then reads ready.
- R7: A toggle or clear on a pipe other than 0 while NAK is 0 or busy is 1 changes no buffer state and raises no interrupt. It sets the error bit, which reads 1 on CONTROL bit 0 and is cleared by that read.
- R8: Toggle and clear while pipe 0 is selected have no effect: no buffer change, no interrupt, no error.
- R9: With read-count mode on, the length field shows the words left and drops by one in the cycle after each DATA read. With it off, in read direction, the length field shows the packet length captured at hand-over.
- R10: In write direction, DATA writes append to the selected buffer. Ready reads 1 while length is below DEPTH. A write to a full buffer is dropped and the length stays at DEPTH.
- R11: In read direction, reading the last held word drops ready to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| pipe_nak | input | NUM_PIPES | Per-pipe response is NAK |
| eng_busy | input | NUM_PIPES | Per-pipe engine busy |
| eng_wr | input | 1 | Engine writes a received word |
| eng_done | input | 1 | Engine marks packet complete |
| eng_pipe | input | PIPE_W | Pipe addressed by the engine |
| eng_wdata | input | DATA_W | Engine write data |
| irq_buf | output | 1 | Buffer interrupt pulse |
| irq_empty | output | 1 | Buffer-empty interrupt pulse |

## Verification
A table of packets covers four pipes, lengths from one word up to a full buffer, and read-count mode on and off. It tells the live remaining count apart from the latched packet length, and it shows that ready falls on the last word. The switch window is sampled at its hold, blank, low-deadline and last-invalid cycles, for a pipe change, a direction change and an unchanged rewrite. Toggle and clear are tried under NAK with idle engine, without NAK, under busy, and on pipe 0. This separates the accepted, refused-with-error and silently-ignored outcomes by their interrupts, buffer length and error bit.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    ADDR_SEL  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_DATA = 2'd3
  } reg_addr_e;

  localparam int REG_W        = 16;
  localparam int SEL_DIR_BIT  = 8;
  localparam int SEL_RCNT_BIT = 9;
  localparam int CTRL_TGL_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int STAT_RDY_BIT = 15;
  localparam int STAT_INV_BIT = 14;
endpackage

// File: rtl/fpc_pipe_buf.sv
module fpc_pipe_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  input  logic              done,
  input  logic              give,
  input  logic              flush,
  output logic [LEN_W-1:0]  len,
  output logic [LEN_W-1:0]  pkt_len,
  output logic              handed,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LEN_W-1:0]  len_q, len_d, pkt_q, pkt_d;
  logic              hand_q, hand_d;
  logic              push_ok, pop_ok;

  assign full    = (len_q == DEPTH_L);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && (len_q != '0) && !flush;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    len_d  = len_q;
    pkt_d  = pkt_q;
    hand_d = hand_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      len_d  = '0;
      pkt_d  = '0;
      hand_d = 1'b0;
    end else begin
      if (push_ok) wptr_d = ptr_inc(wptr_q);
      if (pop_ok)  rptr_d = ptr_inc(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   len_d = len_q + 1'b1;
        2'b01:   len_d = len_q - 1'b1;
        default: len_d = len_q;
      endcase
      if (done || give) begin
        hand_d = 1'b1;
        pkt_d  = len_d;
      end else if (pop_ok && (len_d == '0)) begin
        hand_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      len_q  <= '0;
      pkt_q  <= '0;
      hand_q <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      len_q  <= len_d;
      pkt_q  <= pkt_d;
      hand_q <= hand_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data;
  end

  assign head_data = mem[rptr_q];
  assign len       = len_q;
  assign pkt_len   = pkt_q;
  assign handed    = hand_q;

  // R10: stored length never passes the buffer depth
  assert_len_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= DEPTH_L);
  // R6: an accepted clear leaves the buffer empty and not handed over
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (len_q == '0) && !hand_q);
  // R11: taking the last word releases the hand-over
  assert_last_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && (len_q == LEN_W'(1)) && !push_ok && !done && !give) |=> !hand_q);
endmodule

// File: rtl/fpc_switch_window.sv
module fpc_switch_window #(
  parameter int LEN_W     = 10,
  parameter int HOLD_CYC  = 2,
  parameter int LOW_CYC   = 20,
  parameter int VALID_CYC = 45
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             switch_evt,
  input  logic             live_ready,
  input  logic [LEN_W-1:0] live_len,
  output logic             disp_ready,
  output logic [LEN_W-1:0] disp_len,
  output logic             invalid
);
  localparam int CNT_W = $clog2(VALID_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_C  = CNT_W'(HOLD_CYC);
  localparam logic [CNT_W-1:0] LOW_C   = CNT_W'(LOW_CYC);
  localparam logic [CNT_W-1:0] VALID_C = CNT_W'(VALID_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             snap_rdy_q, snap_rdy_d;
  logic [LEN_W-1:0] snap_len_q, snap_len_d;
  logic             in_hold, in_blank;

  assign in_hold  = (cnt_q != '0) && (cnt_q <= HOLD_C);
  assign in_blank = (cnt_q > HOLD_C);

  always_comb begin
    if (in_blank) begin
      disp_ready = 1'b0;
      disp_len   = '0;
    end else if (in_hold) begin
      disp_ready = snap_rdy_q;
      disp_len   = snap_len_q;
    end else begin
      disp_ready = live_ready;
      disp_len   = live_len;
    end
    invalid = in_blank;
  end

  always_comb begin
    cnt_d      = cnt_q;
    snap_rdy_d = snap_rdy_q;
    snap_len_d = snap_len_q;
    if (switch_evt) begin
      cnt_d      = CNT_W'(1);
      snap_rdy_d = disp_ready;
      snap_len_d = disp_len;
    end else if (cnt_q == VALID_C) begin
      cnt_d = '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      snap_rdy_q <= 1'b0;
      snap_len_q <= '0;
    end else begin
      cnt_q      <= cnt_d;
      snap_rdy_q <= snap_rdy_d;
      snap_len_q <= snap_len_d;
    end
  end

  // R3: old status is held unchanged through the hold part of the window
  assert_hold_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && (cnt_q < HOLD_C)) |=> ($stable(disp_ready) && $stable(disp_len)));
  // R3: ready is low by the low deadline
  assert_low_deadline_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= LOW_C) |-> (!disp_ready && invalid));
  // R3: window ends right after its last invalid cycle
  assert_valid_after_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == VALID_C) && !switch_evt) |=> !invalid);
endmodule

// File: rtl/fpc_cmd_gate.sv
module fpc_cmd_gate #(
  parameter int PIPE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_tgl,
  input  logic              cmd_clr,
  input  logic [PIPE_W-1:0] sel,
  input  logic              nak_sel,
  input  logic              busy_sel,
  input  logic              err_rd,
  output logic              give,
  output logic              flush,
  output logic              irq_buf,
  output logic              irq_empty,
  output logic              err
);
  logic ctrl_pipe, cond_ok, req_any;
  logic irq_buf_q, irq_buf_d, irq_empty_q, irq_empty_d, err_q, err_d;

  assign ctrl_pipe = (sel == '0);
  assign cond_ok   = nak_sel && !busy_sel;
  assign req_any   = (cmd_tgl || cmd_clr) && !ctrl_pipe;
  assign flush     = cmd_clr && !ctrl_pipe && cond_ok;
  assign give      = cmd_tgl && !cmd_clr && !ctrl_pipe && cond_ok;

  always_comb begin
    irq_buf_d   = give || flush;
    irq_empty_d = flush;
    err_d       = err_q;
    if (req_any && !cond_ok) err_d = 1'b1;
    else if (err_rd)         err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_buf_q   <= 1'b0;
      irq_empty_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      irq_buf_q   <= irq_buf_d;
      irq_empty_q <= irq_empty_d;
      err_q       <= err_d;
    end
  end

  assign irq_buf   = irq_buf_q;
  assign irq_empty = irq_empty_q;
  assign err       = err_q;

  // R6: an empty interrupt always comes with the buffer interrupt
  assert_clr_both_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> irq_buf);
  // R5: an interrupt only follows a command issued under NAK and idle engine
  assert_cond_met_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_buf |-> $past(nak_sel && !busy_sel));
  // R8: commands on the control pipe stay silent
  assert_ctrl_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_tgl || cmd_clr) && (sel == '0)) |=> (!irq_buf && !irq_empty));
  // R7: the error bit stays set until it is read
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_rd) |=> err);
endmodule

// File: rtl/fifo_port_ctrl.sv
module fifo_port_ctrl #(
  parameter int NUM_PIPES = 4,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 8,
  parameter int LEN_W     = 10,
  parameter int HOLD_CYC  = 2,
  parameter int LOW_CYC   = 20,
  parameter int VALID_CYC = 45,
  localparam int PIPE_W   = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [1:0]           reg_addr,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  input  logic [NUM_PIPES-1:0] pipe_nak,
  input  logic [NUM_PIPES-1:0] eng_busy,
  input  logic                 eng_wr,
  input  logic                 eng_done,
  input  logic [PIPE_W-1:0]    eng_pipe,
  input  logic [DATA_W-1:0]    eng_wdata,
  output logic                 irq_buf,
  output logic                 irq_empty
);
  import fpc_pkg::*;

  logic [PIPE_W-1:0] sel_q, sel_d, new_sel;
  logic              dir_q, dir_d, rcnt_q, rcnt_d, new_dir;
  logic              sel_wr, switch_evt;
  logic              cmd_wr, cmd_tgl, cmd_clr, err_rd;
  logic              cpu_data_wr, cpu_data_rd;
  logic              give_acc, flush_acc, err;
  logic              live_ready, disp_ready, stat_invalid;
  logic [LEN_W-1:0]  live_len, disp_len;

  logic [DATA_W-1:0] head_a [NUM_PIPES];
  logic [LEN_W-1:0]  len_a  [NUM_PIPES];
  logic [LEN_W-1:0]  pkt_a  [NUM_PIPES];
  logic              hand_a [NUM_PIPES];
  logic              full_a [NUM_PIPES];

  assign new_sel     = reg_wdata[PIPE_W-1:0];
  assign new_dir     = reg_wdata[SEL_DIR_BIT];
  assign sel_wr      = reg_wr && (reg_addr == ADDR_SEL);
  assign switch_evt  = sel_wr && ((new_sel != sel_q) || (new_dir != dir_q));
  assign cmd_wr      = reg_wr && (reg_addr == ADDR_CTRL);
  assign cmd_tgl     = cmd_wr && reg_wdata[CTRL_TGL_BIT];
  assign cmd_clr     = cmd_wr && reg_wdata[CTRL_CLR_BIT];
  assign err_rd      = reg_rd && (reg_addr == ADDR_CTRL);
  assign cpu_data_wr = reg_wr && (reg_addr == ADDR_DATA) && dir_q;
  assign cpu_data_rd = reg_rd && (reg_addr == ADDR_DATA) && !dir_q;

  always_comb begin
    sel_d  = sel_q;
    dir_d  = dir_q;
    rcnt_d = rcnt_q;
    if (sel_wr) begin
      sel_d  = new_sel;
      dir_d  = new_dir;
      rcnt_d = reg_wdata[SEL_RCNT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dir_q  <= 1'b0;
      rcnt_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      dir_q  <= dir_d;
      rcnt_q <= rcnt_d;
    end
  end

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic eng_hit, is_sel;
    assign eng_hit = eng_wr && (eng_pipe == PIPE_W'(p));
    assign is_sel  = (sel_q == PIPE_W'(p));

    fpc_pipe_buf #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .LEN_W  (LEN_W)
    ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (eng_hit || (cpu_data_wr && is_sel)),
      .push_data (eng_hit ? eng_wdata : reg_wdata[DATA_W-1:0]),
      .pop       (cpu_data_rd && is_sel),
      .head_data (head_a[p]),
      .done      (eng_done && (eng_pipe == PIPE_W'(p))),
      .give      (give_acc && is_sel),
      .flush     (flush_acc && is_sel),
      .len       (len_a[p]),
      .pkt_len   (pkt_a[p]),
      .handed    (hand_a[p]),
      .full      (full_a[p])
    );
  end

  fpc_cmd_gate #(
    .PIPE_W (PIPE_W)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_tgl   (cmd_tgl),
    .cmd_clr   (cmd_clr),
    .sel       (sel_q),
    .nak_sel   (pipe_nak[sel_q]),
    .busy_sel  (eng_busy[sel_q]),
    .err_rd    (err_rd),
    .give      (give_acc),
    .flush     (flush_acc),
    .irq_buf   (irq_buf),
    .irq_empty (irq_empty),
    .err       (err)
  );

  assign live_ready = dir_q ? !full_a[sel_q] : hand_a[sel_q];
  assign live_len   = (dir_q || rcnt_q) ? len_a[sel_q] : pkt_a[sel_q];

  fpc_switch_window #(
    .LEN_W     (LEN_W),
    .HOLD_CYC  (HOLD_CYC),
    .LOW_CYC   (LOW_CYC),
    .VALID_CYC (VALID_CYC)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .switch_evt (switch_evt),
    .live_ready (live_ready),
    .live_len   (live_len),
    .disp_ready (disp_ready),
    .disp_len   (disp_len),
    .invalid    (stat_invalid)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_SEL: begin
        reg_rdata[PIPE_W-1:0]   = sel_q;
        reg_rdata[SEL_DIR_BIT]  = dir_q;
        reg_rdata[SEL_RCNT_BIT] = rcnt_q;
      end
      ADDR_CTRL: reg_rdata[0] = err;
      ADDR_STAT: begin
        reg_rdata[STAT_RDY_BIT] = disp_ready;
        reg_rdata[STAT_INV_BIT] = stat_invalid;
        reg_rdata[LEN_W-1:0]    = disp_len;
      end
      default: reg_rdata[DATA_W-1:0] = head_a[sel_q];
    endcase
  end
endmodule

// File: tb/fifo_port_ctrl_tb.sv
module fifo_port_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP    = 4;
  localparam int HOLD  = 2;
  localparam int LOW   = 20;
  localparam int VALID = 45;
  localparam int DEPTH = 8;

  localparam int T_PIPE [4] = '{1, 2, 3, 1};
  localparam int T_N    [4] = '{3, 5, 1, 8};
  localparam int T_BASE [4] = '{256, 512, 768, 1024};
  localparam int T_RCNT [4] = '{0, 1, 0, 1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NP-1:0] pipe_nak = '0, eng_busy = '0;
  logic        eng_wr = 1'b0, eng_done = 1'b0;
  logic [1:0]  eng_pipe = '0;
  logic [15:0] eng_wdata = '0;
  logic        irq_buf, irq_empty;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_port_ctrl #(
    .NUM_PIPES (NP), .DATA_W (16), .DEPTH (DEPTH), .LEN_W (10),
    .HOLD_CYC (HOLD), .LOW_CYC (LOW), .VALID_CYC (VALID)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_rd (reg_rd),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .pipe_nak (pipe_nak), .eng_busy (eng_busy), .eng_wr (eng_wr),
    .eng_done (eng_done), .eng_pipe (eng_pipe), .eng_wdata (eng_wdata),
    .irq_buf (irq_buf), .irq_empty (irq_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic eng_push(input int p, input int d);
    @(negedge clk);
    eng_pipe = 2'(p); eng_wdata = 16'(d); eng_wr = 1'b1;
    @(negedge clk);
    eng_wr = 1'b0;
  endtask

  task automatic eng_finish(input int p);
    @(negedge clk);
    eng_pipe = 2'(p); eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic check_stat(input string req, input int rdy, input int inv, input int len);
    logic [15:0] v;
    peek(2'd2, v);
    chk({req, " ready"}, int'(v[15]), rdy);
    chk({req, " invalid"}, int'(v[14]), inv);
    chk({req, " length"}, int'(v[9:0]), len);
  endtask

  function automatic logic [15:0] sel_val(input int p, input int dir, input int rcnt);
    return 16'((rcnt << 9) | (dir << 8) | p);
  endfunction

  initial begin
    logic [15:0] v;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    check_stat("R1", 0, 0, 0);
    peek(2'd0, v); chk("R1 select", int'(v), 0);
    peek(2'd1, v); chk("R1 error", int'(v[0]), 0);
    chk("R1 irq_buf", int'(irq_buf), 0);
    chk("R1 irq_empty", int'(irq_empty), 0);

    // R2 / R9 / R11: packet table
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < T_N[i]; k++) eng_push(T_PIPE[i], T_BASE[i] + k);
      eng_finish(T_PIPE[i]);
      reg_write(2'd0, sel_val(T_PIPE[i], 0, T_RCNT[i]));
      step(VALID);
      check_stat("R2 table", 1, 0, T_N[i]);
      for (int k = 0; k < T_N[i]; k++) begin
        reg_read(2'd3, v);
        chk("R2 data order", int'(v), T_BASE[i] + k);
        peek(2'd2, v);
        if (k < T_N[i] - 1)
          chk("R9 length after read", int'(v[9:0]), (T_RCNT[i] != 0) ? T_N[i] - k - 1 : T_N[i]);
      end
      peek(2'd2, v);
      chk("R11 ready after last word", int'(v[15]), 0);
    end

    // R3: pipe switch window, sel now pipe 1 with read count on
    for (int k = 0; k < 4; k++) eng_push(1, 16 + k);
    eng_finish(1);
    eng_push(2, 32); eng_push(2, 33);
    eng_finish(2);
    check_stat("R3 before switch", 1, 0, 4);
    reg_write(2'd0, sel_val(2, 0, 0));
    check_stat("R3 hold first cycle", 1, 0, 4);
    step(HOLD - 1);
    check_stat("R3 hold last cycle", 1, 0, 4);
    step(1);
    check_stat("R3 blank start", 0, 1, 0);
    step(LOW - HOLD - 1);
    check_stat("R3 low deadline", 0, 1, 0);
    step(VALID - LOW);
    check_stat("R3 last invalid", 0, 1, 0);
    step(1);
    check_stat("R3 new pipe valid", 1, 0, 2);

    // R4: direction change, then unchanged rewrite
    reg_write(2'd0, sel_val(2, 1, 0));
    step(HOLD);
    check_stat("R4 direction blank", 0, 1, 0);
    step(VALID - HOLD);
    check_stat("R4 write dir valid", 1, 0, 2);
    reg_write(2'd0, sel_val(2, 1, 0));
    step(HOLD);
    check_stat("R4 no window on same value", 1, 0, 2);

    // R10: fill to full in write direction
    for (int k = 0; k < 6; k++) reg_write(2'd3, 16'(64 + k));
    check_stat("R10 full", 0, 0, DEPTH);
    reg_write(2'd3, 16'h00ff);
    check_stat("R10 write to full dropped", 0, 0, DEPTH);

    // R7: refused commands
    pipe_nak = '0; eng_busy = '0;
    reg_write(2'd1, 16'h0002);
    chk("R7 no irq without NAK", int'(irq_buf), 0);
    check_stat("R7 length kept", 0, 0, DEPTH);
    reg_read(2'd1, v); chk("R7 error set", int'(v[0]), 1);
    reg_read(2'd1, v); chk("R7 error cleared by read", int'(v[0]), 0);
    pipe_nak = 4'b1111; eng_busy = 4'b0100;
    reg_write(2'd1, 16'h0001);
    chk("R7 no irq while busy", int'(irq_buf), 0);
    reg_read(2'd1, v); chk("R7 error on busy", int'(v[0]), 1);

    // R6: accepted clear
    eng_busy = '0;
    reg_write(2'd1, 16'h0002);
    chk("R6 irq_buf", int'(irq_buf), 1);
    chk("R6 irq_empty", int'(irq_empty), 1);
    check_stat("R6 emptied, ready for writes", 1, 0, 0);
    step(1);
    chk("R6 irq_buf one cycle", int'(irq_buf), 0);
    chk("R6 irq_empty one cycle", int'(irq_empty), 0);

    // R5: accepted toggle on pipe 3
    reg_write(2'd0, sel_val(3, 0, 1));
    step(VALID);
    eng_push(3, 48); eng_push(3, 49);
    check_stat("R5 before toggle", 0, 0, 2);
    reg_write(2'd1, 16'h0001);
    chk("R5 irq_buf", int'(irq_buf), 1);
    chk("R5 irq_empty stays low", int'(irq_empty), 0);
    check_stat("R5 handed over", 1, 0, 2);
    reg_read(2'd3, v); chk("R5 data 0", int'(v), 48);
    reg_read(2'd3, v); chk("R5 data 1", int'(v), 49);
    check_stat("R11 drained after toggle", 0, 0, 0);

    // R8: control pipe ignores both commands
    reg_write(2'd0, sel_val(0, 0, 1));
    step(VALID);
    eng_push(0, 7);
    reg_write(2'd1, 16'h0001);
    chk("R8 toggle no irq", int'(irq_buf), 0);
    check_stat("R8 toggle no hand-over", 0, 0, 1);
    reg_write(2'd1, 16'h0002);
    chk("R8 clear no irq_empty", int'(irq_empty), 0);
    check_stat("R8 clear kept data", 0, 0, 1);
    reg_read(2'd1, v); chk("R8 no error", int'(v[0]), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule